// File: doc/BRIEF.md
# Isolated Digital IO Register Block with Change Interrupt

This block is the host-facing register file of a digital IO card with sixteen output lines and sixteen isolated input lines. The host reaches it through a small byte bus: a 3-bit address, a read strobe, a write strobe, write data and registered read data. The block holds two output bytes that drive the output lines. It samples the sixteen input lines through a synchronizer, and it watches every input for a level change in either direction.

Several addresses act differently for a read and for a write, and some accesses exist only for their side effect. Reading the interrupt-control address arms change interrupts, and writing it (any value) disarms them. Reading the filter-control address turns on a stored filter-enable bit, and writing it turns that bit off. Writing the low input address acknowledges a pending interrupt. When interrupts are armed, a change on either input byte sets a sticky pending flag for that byte. The level interrupt output is high while any flag is set.

Top module: `iso_io_regs`

## Requirements
- R1: After reset the output lines are 0, read data is 0, the interrupt line is low, the filter enable is low and interrupts are disarmed.
- R2: A write to offset 0 loads output lines 7:0 and a write to offset 4 loads lines 15:8. A read of the same offset returns the latched byte, and the latches change on no other access.
- R3: A read of offset 1 returns synchronized inputs 7:0 and a read of offset 5 returns inputs 15:8. A pin value is visible to reads from the second clock edge after it is applied. Read data appears after the edge that samples the read strobe and holds until the next read.
- R4: A read of offset 2 arms change interrupts. A write of any value to offset 2 disarms them and clears every pending flag.
- R5: A read of offset 3 sets filter_en to 1, and a write of any value to offset 3 sets it to 0.
- R6: While armed, a rising or falling change on any input of a byte sets that byte's pending flag on the third clock edge after the pin changes, and irq is high while any flag is set.
- R7: A read of offset 6 returns the status byte: bit 0 is the pending flag of inputs 7:0, bit 1 that of inputs 15:8, bit 2 equals irq, and bits 7:3 are 0.
- R8: A write of any value to offset 1 clears the pending flags. A change that is detected while interrupts are disarmed is dropped and never becomes pending.
- R9: A change detected on the same edge as an acknowledge write to offset 1 wins: its flag is set after that edge.
- R10: Writes to offsets 5, 6 and 7 have no effect. Reads of offsets 2, 3 and 7 return 0.
- R11: When the read and write strobes are both high in one cycle, only the write takes effect and the read data holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| in_pins | input | 16 | Input lines, asynchronous to clk |
| out_pins | output | 16 | Output latch lines |
| irq | output | 1 | Level interrupt to the host |
| filter_en | output | 1 | Stored input-filter enable |

## Verification
The bound assertions check on every cycle that a disarm write drops irq, that a lone acknowledge drops it, that irq stays set until one of those writes, that an armed change raises it, that the output latches stay put unless they are written, and that a filter read sets the enable. Read data contents, the synchronizer latency, dropping a change while disarmed, the status byte encoding and the collision between a change and an acknowledge can be seen only through the bench scenarios. There a behavioural reference model with a pin history queue is compared against every output on every clock.

// File: rtl/iso_io_pkg.sv
package iso_io_pkg;

    localparam logic [2:0] ADR_IRQ_CTL = 3'd2;
    localparam logic [2:0] ADR_FILTER  = 3'd3;
    localparam logic [2:0] ADR_STATUS  = 3'd6;
    localparam logic [2:0] ADR_ACK     = 3'd1;

    // Output byte p sits at offset 4*p, input byte p right after it.
    function automatic logic [2:0] out_addr(input int p);
        return 3'(p * 4);
    endfunction

    function automatic logic [2:0] in_addr(input int p);
        return 3'(p * 4 + 1);
    endfunction

endpackage

// File: rtl/iso_io_sync.sv
module iso_io_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (!rst_n) stage_q[i] <= '0;
            else        stage_q[i] <= stage_d[i];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/iso_io_chg.sv
module iso_io_chg #(
    parameter int PORT_W    = 8,
    parameter int NUM_PORTS = 2,
    localparam int PIN_W    = PORT_W * NUM_PORTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_W-1:0]     cur,
    output logic [NUM_PORTS-1:0] chg
);

    logic [PIN_W-1:0] prev_q;
    logic [PIN_W-1:0] prev_d;

    assign prev_d = cur;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // One change flag per byte: any bit toggled, either direction.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign chg[p] = |(cur[p*PORT_W +: PORT_W] ^ prev_q[p*PORT_W +: PORT_W]);
    end

endmodule

// File: rtl/iso_io_core.sv
module iso_io_core
    import iso_io_pkg::*;
#(
    parameter int PORT_W    = 8,
    parameter int NUM_PORTS = 2,
    localparam int PIN_W    = PORT_W * NUM_PORTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           addr,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [PORT_W-1:0]    wdata,
    input  logic [PIN_W-1:0]     in_sync,
    input  logic [NUM_PORTS-1:0] chg,
    output logic [PIN_W-1:0]     out_pins,
    output logic [PORT_W-1:0]    rdata,
    output logic                 irq,
    output logic                 irq_en,
    output logic                 filter_en
);

    typedef struct packed {
        logic [PIN_W-1:0]     outl;
        logic                 en;
        logic                 filt;
        logic [NUM_PORTS-1:0] pend;
        logic [PORT_W-1:0]    rdata;
    } state_t;

    state_t st_d, st_q;
    logic   rd_ok;
    logic   wr_ctl;
    logic   wr_ack;

    always_comb begin
        st_d   = st_q;
        rd_ok  = rd_en && !wr_en;
        wr_ctl = wr_en && (addr == ADR_IRQ_CTL);
        wr_ack = wr_en && (addr == ADR_ACK);

        for (int p = 0; p < NUM_PORTS; p++) begin
            if (wr_en && addr == out_addr(p)) begin
                st_d.outl[p*PORT_W +: PORT_W] = wdata;
            end
        end

        // Disarm clears everything; an acknowledge clears, but a change
        // detected on the same edge is merged back in afterwards.
        if (wr_ctl) begin
            st_d.pend = '0;
        end else begin
            if (wr_ack) st_d.pend = '0;
            if (st_q.en) st_d.pend = st_d.pend | chg;
        end

        if (wr_ctl)                              st_d.en = 1'b0;
        else if (rd_ok && addr == ADR_IRQ_CTL)   st_d.en = 1'b1;

        if (wr_en && addr == ADR_FILTER)         st_d.filt = 1'b0;
        else if (rd_ok && addr == ADR_FILTER)    st_d.filt = 1'b1;

        if (rd_ok) begin
            st_d.rdata = '0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (addr == out_addr(p)) st_d.rdata = st_q.outl[p*PORT_W +: PORT_W];
                if (addr == in_addr(p))  st_d.rdata = in_sync[p*PORT_W +: PORT_W];
            end
            if (addr == ADR_STATUS) begin
                st_d.rdata[NUM_PORTS-1:0] = st_q.pend;
                st_d.rdata[NUM_PORTS]     = |st_q.pend;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_pins  = st_q.outl;
    assign rdata     = st_q.rdata;
    assign irq       = |st_q.pend;
    assign irq_en    = st_q.en;
    assign filter_en = st_q.filt;

endmodule

// File: rtl/iso_io_regs.sv
module iso_io_regs #(
    parameter int PORT_W      = 8,
    parameter int NUM_PORTS   = 2,
    parameter int SYNC_STAGES = 2,
    localparam int PIN_W      = PORT_W * NUM_PORTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PIN_W-1:0]  in_pins,
    output logic [PIN_W-1:0]  out_pins,
    output logic              irq,
    output logic              filter_en
);

    logic [PIN_W-1:0]     sync_w;
    logic [NUM_PORTS-1:0] chg_w;
    logic                 en_w;

    iso_io_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (in_pins),
        .dout  (sync_w)
    );

    iso_io_chg #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_chg (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (sync_w),
        .chg   (chg_w)
    );

    iso_io_core #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .rd_en     (bus_rd),
        .wr_en     (bus_wr),
        .wdata     (bus_wdata),
        .in_sync   (sync_w),
        .chg       (chg_w),
        .out_pins  (out_pins),
        .rdata     (bus_rdata),
        .irq       (irq),
        .irq_en    (en_w),
        .filter_en (filter_en)
    );

endmodule

// File: rtl/iso_io_chk.sv
module iso_io_chk #(
    parameter int OUT_W = 16,
    parameter int NPORT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       addr,
    input logic             rd_en,
    input logic             wr_en,
    input logic [OUT_W-1:0] out_pins,
    input logic             irq,
    input logic             filter_en,
    input logic             irq_en,
    input logic [NPORT-1:0] chg
);

    p_disarm_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd2) |=> !irq);

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd1 && !(irq_en && |chg)) |=> !irq);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_en && (addr == 3'd1 || addr == 3'd2))) |=> irq);

    p_change_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && |chg && !(wr_en && addr == 3'd2)) |=> irq);

    p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == 3'd0 || addr == 3'd4)) |=> $stable(out_pins));

    p_filter_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 3'd3) |=> filter_en);

endmodule

bind iso_io_regs iso_io_chk #(.OUT_W(PORT_W * NUM_PORTS), .NPORT(NUM_PORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (bus_addr),
    .rd_en     (bus_rd),
    .wr_en     (bus_wr),
    .out_pins  (out_pins),
    .irq       (irq),
    .filter_en (filter_en),
    .irq_en    (en_w),
    .chg       (chg_w)
);

// File: tb/iso_io_regs_test.sv
`timescale 1ns/1ps
module iso_io_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] in_pins = '0;
    logic [15:0] out_pins;
    logic        irq;
    logic        filter_en;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    always #5 clk = ~clk;

    iso_io_regs uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .in_pins   (in_pins),
        .out_pins  (out_pins),
        .irq       (irq),
        .filter_en (filter_en)
    );

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_out;
    bit          m_en, m_filt;
    bit   [1:0]  m_pend;
    logic [7:0]  m_rdata;
    logic [15:0] hist[$];
    logic [15:0] seen, older;
    bit   [1:0]  moved;
    bit   [1:0]  np;
    bit          rd_only;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = '0; m_en = 0; m_filt = 0; m_pend = '0; m_rdata = '0;
            hist = '{16'h0, 16'h0, 16'h0};
        end else begin
            seen     = hist[1];
            older    = hist[2];
            moved[0] = (seen[7:0]  != older[7:0]);
            moved[1] = (seen[15:8] != older[15:8]);
            rd_only  = bus_rd && !bus_wr;
            if (rd_only) begin
                case (bus_addr)
                    3'd0: m_rdata = m_out[7:0];
                    3'd1: m_rdata = seen[7:0];
                    3'd4: m_rdata = m_out[15:8];
                    3'd5: m_rdata = seen[15:8];
                    3'd6: m_rdata = {5'b0, (m_pend != 0), m_pend};
                    default: m_rdata = 8'h00;
                endcase
            end
            if (bus_wr && bus_addr == 3'd2) np = 2'b00;
            else begin
                np = (bus_wr && bus_addr == 3'd1) ? 2'b00 : m_pend;
                if (m_en) np = np | moved;
            end
            m_pend = np;
            if (bus_wr && bus_addr == 3'd2)       m_en = 0;
            else if (rd_only && bus_addr == 3'd2) m_en = 1;
            if (bus_wr && bus_addr == 3'd3)       m_filt = 0;
            else if (rd_only && bus_addr == 3'd3) m_filt = 1;
            if (bus_wr && bus_addr == 3'd0) m_out[7:0]  = bus_wdata;
            if (bus_wr && bus_addr == 3'd4) m_out[15:8] = bus_wdata;
            hist.push_front(in_pins);
            void'(hist.pop_back());
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 model out_pins",  32'(out_pins),  32'(m_out));
            check("R3 model bus_rdata", 32'(bus_rdata), 32'(m_rdata));
            check("R6 model irq",       32'(irq),       32'(m_pend != 0));
            check("R5 model filter_en", 32'(filter_en), 32'(m_filt));
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); #1;
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            done = 1;
            summary();
            $finish;
        end
    end

    logic [7:0] rv;

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 out_pins", 32'(out_pins), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 filter_en", 32'(filter_en), 0);
        check("R1 rdata", 32'(bus_rdata), 0);
        in_pins = 16'h00F0;
        idle(4);
        check("R1 disarmed after reset", 32'(irq), 0);

        // R2 output latches
        bus_write(3'd0, 8'hA5);
        bus_write(3'd4, 8'h3C);
        check("R2 out_pins", 32'(out_pins), 32'h3CA5);
        bus_read(3'd0, rv); check("R2 read low", 32'(rv), 32'hA5);
        bus_read(3'd4, rv); check("R2 read high", 32'(rv), 32'h3C);

        // R3 input reads and latency
        @(negedge clk); #1; in_pins = 16'h1234;
        bus_read(3'd1, rv);
        check("R3 one edge is too early", 32'(rv), 32'hF0);
        bus_read(3'd1, rv); check("R3 read in low", 32'(rv), 32'h34);
        bus_read(3'd5, rv); check("R3 read in high", 32'(rv), 32'h12);
        idle(2);
        check("R3 rdata holds", 32'(bus_rdata), 32'h12);

        // R4 arm, R6 rising change, R7 status
        bus_read(3'd2, rv); check("R10 read ctl is 0", 32'(rv), 0);
        idle(2);
        check("R6 no change no irq", 32'(irq), 0);
        @(negedge clk); #1; in_pins = 16'h1235;
        idle(2);
        check("R6 not yet set", 32'(irq), 0);
        idle(1);
        check("R6 irq set on third edge", 32'(irq), 1);
        bus_read(3'd6, rv); check("R7 status low byte", 32'(rv), 32'h05);

        // R8 acknowledge
        bus_write(3'd1, 8'h00);
        check("R8 ack clears", 32'(irq), 0);
        bus_read(3'd6, rv); check("R7 status idle", 32'(rv), 32'h00);

        // R6 falling change high byte
        @(negedge clk); #1; in_pins = 16'h0235;
        idle(4);
        check("R6 falling edge irq", 32'(irq), 1);
        bus_read(3'd6, rv); check("R7 status high byte", 32'(rv), 32'h06);

        // R4 disarm clears and drops later changes (R8)
        bus_write(3'd2, 8'h5A);
        check("R4 disarm clears", 32'(irq), 0);
        @(negedge clk); #1; in_pins = 16'hFFFF;
        idle(5);
        check("R8 change while disarmed dropped", 32'(irq), 0);
        bus_read(3'd2, rv);
        idle(4);
        check("R8 no late pending after rearm", 32'(irq), 0);

        // R9 change on the same edge as acknowledge
        @(negedge clk); #1; in_pins = 16'hFF00;
        @(negedge clk); #1;
        @(negedge clk); #1; bus_addr = 3'd1; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk); #1; bus_wr = 1'b0;
        check("R9 change beats ack", 32'(irq), 1);
        bus_read(3'd6, rv); check("R9 status", 32'(rv), 32'h05);
        bus_write(3'd1, 8'hFF);
        check("R8 ack any value", 32'(irq), 0);

        // R5 filter enable
        bus_read(3'd3, rv);
        check("R5 filter on", 32'(filter_en), 1);
        check("R10 read filter is 0", 32'(rv), 0);
        bus_write(3'd3, 8'hFF);
        check("R5 filter off", 32'(filter_en), 0);

        // R10 ignored writes
        @(negedge clk); #1; in_pins = 16'hFF01;
        idle(4);
        check("R10 pending before", 32'(irq), 1);
        bus_write(3'd5, 8'hFF);
        bus_write(3'd6, 8'hFF);
        bus_write(3'd7, 8'hFF);
        check("R10 irq kept", 32'(irq), 1);
        check("R10 outputs kept", 32'(out_pins), 32'h3CA5);
        bus_read(3'd7, rv); check("R10 read 7 is 0", 32'(rv), 0);
        bus_write(3'd1, 8'h00);

        // R11 simultaneous strobes
        bus_read(3'd4, rv);
        @(negedge clk); #1;
        bus_addr = 3'd0; bus_wdata = 8'h77; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk); #1; bus_wr = 1'b0; bus_rd = 1'b0;
        check("R11 write done", 32'(out_pins), 32'h3C77);
        check("R11 rdata held", 32'(bus_rdata), 32'h3C);

        idle(3);
        done = 1;
        summary();
        $finish;
    end

endmodule